// File: doc/BRIEF.md
# System Reset Control Register

This block is a one-byte I/O register that the processor writes to start a system reset. It sits at I/O address 0x0CF9 and is reached through a simple single-cycle write/read strobe interface with an address compare. A write that raises the "go" bit (bit 2) from 0 to 1 fires a reset. The "scope" bit (bit 1) of that same write chooses the kind of reset. With bit 1 clear, only the processor is reset. With bit 1 set, the reset is a full-system one: a hard-reset pulse goes to the chipset and the peripherals, including the keyboard controller. A request also goes to the bridge to reload its configuration defaults. The processor reset is issued in either case.

The register holds what was written, except that bit 1 is never kept. A read returns the held value with bit 2 shown as 0. So software cannot read back the go bit, and the scope bit always reads as 0. Because the register only reacts to a rising go bit, software must write a value with bit 2 clear before a second reset can be started. The reset pulses do not clear the register. Only the block reset input does that.

Top module: `sysrst_ctl`

## Requirements
- R1: During and after the block reset, the held value is 0x00 and the three pulse outputs are low.
- R2: A write strobe with the address equal to 0x0CF9 stores the write byte with bit 1 forced to 0.
- R3: A read strobe at 0x0CF9 returns the held value with bit 2 forced to 0, in the same cycle as the strobe. When there is no read strobe, or the address differs, the read data is 0x00.
- R4: A write at 0x0CF9 with bit 2 set, while the held bit 2 is 0, raises `cpu_rst_pulse` for exactly one cycle. The pulse starts in the cycle after the write cycle.
- R5: When a triggering write has bit 1 = 1, `hard_rst_pulse` and `cfg_reload_pulse` are high in the same single cycle as `cpu_rst_pulse`.
- R6: When a triggering write has bit 1 = 0, only `cpu_rst_pulse` fires, and `hard_rst_pulse` and `cfg_reload_pulse` stay low.
- R7: A write with bit 2 set while the held bit 2 is already 1 produces no pulse.
- R8: A write whose address is not 0x0CF9 changes neither the held value nor any output.
- R9: After a write that clears bit 2, a later write that sets bit 2 triggers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| cpu_rst_pulse | output | 1 | One-cycle processor reset request |
| hard_rst_pulse | output | 1 | One-cycle chipset and peripheral hard reset |
| cfg_reload_pulse | output | 1 | One-cycle request to reload bridge configuration defaults |

## Verification
Read data is combinational, so the bench checks it in the same cycle that it drives the read strobe, a moment after the inputs settle. The held value and the pulses go through one register each. A write is therefore judged one clock later, by sampling the pulse outputs at the falling edge after the rising edge that captured the write. The behavioural model in the bench updates its expected held value and pulses at that same edge. Every cycle compares all three pulses against the model, so a pulse that is late, missing, extra or longer than one cycle shows up as a mismatch.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic cpu;
        logic hard;
        logic reload;
    } pulse_t;

    typedef struct packed {
        logic [REG_W-1:0] val;
    } hold_t;

endpackage

// File: rtl/sysrst_decode.sv
module sysrst_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_match;

    always_comb begin
        addr_match = (io_addr == PORT_ADDR);
        wr_hit     = io_wr && addr_match;
        rd_hit     = io_rd && addr_match;
    end

endmodule

// File: rtl/sysrst_store.sv
module sysrst_store
    import sysrst_pkg::*;
#(
    parameter int GO_BIT    = 2,
    parameter int SCOPE_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             trig,
    output logic             go_held
);

    localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << SCOPE_BIT);
    localparam logic [REG_W-1:0] SHOW_MASK = ~(REG_W'(1) << GO_BIT);

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        trig   = wr_hit && wdata[GO_BIT] && !hold_q.val[GO_BIT];
        if (wr_hit) begin
            hold_d.val = wdata & KEEP_MASK;
        end
        rdata   = rd_hit ? (hold_q.val & SHOW_MASK) : '0;
        go_held = hold_q.val[GO_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    AST_MISS_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(hold_q.val));                                  // R8
    AST_SCOPE_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !hold_q.val[SCOPE_BIT]);                                 // R2

endmodule

// File: rtl/sysrst_pulse.sv
module sysrst_pulse
    import sysrst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic scope,
    output logic cpu_rst,
    output logic hard_rst,
    output logic cfg_reload
);

    pulse_t pulse_d, pulse_q;

    always_comb begin
        pulse_d        = '0;
        pulse_d.cpu    = trig;
        pulse_d.hard   = trig && scope;
        pulse_d.reload = trig && scope;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign cpu_rst    = pulse_q.cpu;
    assign hard_rst   = pulse_q.hard;
    assign cfg_reload = pulse_q.reload;

    AST_CPU_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q.cpu |=> !pulse_q.cpu);                                      // R4
    AST_HARD_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q.hard |-> pulse_q.cpu);                                      // R5

endmodule

// File: rtl/sysrst_ctl.sv
module sysrst_ctl
    import sysrst_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
    parameter int                GO_BIT    = 2,
    parameter int                SCOPE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    output logic              cpu_rst_pulse,
    output logic              hard_rst_pulse,
    output logic              cfg_reload_pulse
);

    logic wr_hit;
    logic rd_hit;
    logic trig;
    logic go_held;

    sysrst_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    sysrst_store #(
        .GO_BIT    (GO_BIT),
        .SCOPE_BIT (SCOPE_BIT)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .wdata   (io_wdata),
        .rdata   (io_rdata),
        .trig    (trig),
        .go_held (go_held)
    );

    sysrst_pulse u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .scope      (io_wdata[SCOPE_BIT]),
        .cpu_rst    (cpu_rst_pulse),
        .hard_rst   (hard_rst_pulse),
        .cfg_reload (cfg_reload_pulse)
    );

    AST_PULSE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_pulse |-> $past(wr_hit));                                    // R4
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        go_held |=> !cpu_rst_pulse);                                         // R7
    AST_CPU_ONLY_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_pulse && !hard_rst_pulse) |-> !$past(io_wdata[SCOPE_BIT])); // R6
    AST_RELOAD_WITH_HARD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reload_pulse == hard_rst_pulse);                                 // R5

endmodule

// File: tb/sysrst_ctl_bench.sv
module sysrst_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] io_addr;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        cpu_rst_pulse;
    logic        hard_rst_pulse;
    logic        cfg_reload_pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int m_held = 0;
    int m_cpu  = 0;
    int m_hard = 0;

    always #4 clk = ~clk;

    sysrst_ctl u_sysrst_ctl (
        .clk              (clk),
        .rst_n            (rst_n),
        .io_addr          (io_addr),
        .io_wr            (io_wr),
        .io_rd            (io_rd),
        .io_wdata         (io_wdata),
        .io_rdata         (io_rdata),
        .cpu_rst_pulse    (cpu_rst_pulse),
        .hard_rst_pulse   (hard_rst_pulse),
        .cfg_reload_pulse (cfg_reload_pulse)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one access per cycle; starts and ends at a falling edge
    task automatic access(input bit wr, input bit rd, input int addr, input int data, input string req);
        bit hit;
        io_wr    = wr;
        io_rd    = rd;
        io_addr  = addr[15:0];
        io_wdata = data[7:0];
        #1;
        hit = (addr == 'h0CF9);
        if (rd)
            check(req, "rdata", io_rdata, hit ? (m_held & 'hFB) : 0);
        m_cpu  = 0;
        m_hard = 0;
        if (wr && hit) begin
            if (((data >> 2) & 1) == 1 && ((m_held >> 2) & 1) == 0) begin
                m_cpu  = 1;
                m_hard = (data >> 1) & 1;
            end
            m_held = data & 'hFD;
        end
        @(negedge clk);
        io_wr = 1'b0;
        io_rd = 1'b0;
        check(req, "cpu_rst_pulse", cpu_rst_pulse, m_cpu);
        check(req, "hard_rst_pulse", hard_rst_pulse, m_hard);
        check(req, "cfg_reload_pulse", cfg_reload_pulse, m_hard);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1", "cpu in reset", cpu_rst_pulse, 0);
        check("R1", "hard in reset", hard_rst_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        access(0, 1, 'h0CF9, 0, "R1");        // read 0x00 after reset
        access(1, 0, 'h0CF9, 'hFB, "R2");     // bit2 clear: no reset, held 0xF9
        access(0, 1, 'h0CF9, 0, "R2");
        access(0, 1, 'h0CF8, 0, "R3");        // wrong address reads 0
        access(1, 0, 'h0CF9, 'h03, "R2");     // held 0x01
        access(0, 1, 'h0CF9, 0, "R3");
        access(1, 0, 'h0CF9, 'h06, "R5");     // full reset
        access(0, 1, 'h0CF9, 0, "R3");        // bit2 hidden, pulses gone (R4)
        access(1, 0, 'h0CF9, 'h06, "R7");     // already set: nothing
        access(1, 0, 'h0CF9, 'hFF, "R7");
        access(0, 1, 'h0CF9, 0, "R3");
        access(1, 0, 'h0CF9, 'h00, "R9");     // clear go
        access(1, 0, 'h0CF9, 'h04, "R6");     // cpu only
        access(0, 0, 'h0CF9, 0, "R4");        // idle: single cycle
        access(1, 0, 'h0CF9, 'h00, "R9");
        access(1, 0, 'h0CF9, 'h0E, "R9");     // retrigger full
        access(1, 0, 'h0CF9, 'h00, "R8");
        access(1, 0, 'h0CF8, 'h07, "R8");     // miss: no pulse
        access(1, 0, 'h1CF9, 'h37, "R8");     // miss: no pulse
        access(0, 1, 'h0CF9, 0, "R8");        // still 0x00
        access(1, 1, 'h0CF9, 'hA4, "R6");     // read sees old value
        access(0, 1, 'h0CF9, 0, "R3");        // 0xA0
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule